// File: doc/BRIEF.md
# 16-bit Framed Serial Register Target

This block is the target end of a four-wire serial link: an active-low select, a serial clock, a data input and a data output with its own enable. Every transfer is a 16-clock packet. The first eight sampled bits are a control byte, which carries a direction flag, a command/data flag and a high/low half flag followed by five padding bits. The last eight bits are the payload, most significant bit first. A 16-bit command address takes two write packets: the high half first, then the low half. Writes with the command/data flag set deliver parameter or pixel bytes.

A read packet turns the line around after its control byte. For a register read, the block raises a one-cycle read request with the current address. It then shifts the byte on its read-data input out in the eight payload clocks. For a memory read, a run of dummy clocks comes first, and only then are the request and the data sent. The select line must rise after any read before the next packet. All serial pins are synchronized into the system clock, which must run at least four times faster than the serial clock. A mode input picks the serial clock edge that samples input. The output changes on the other edge.

Top module: `spi16_reg_slave`

## Requirements
- R1: While cs_n is high, no strobe or read request is raised and clock or data activity has no effect. A falling cs_n starts a new packet at bit 0 whatever level sclk has, and any packet cut short by a rising cs_n is dropped with no strobe.
- R2: With sample_fall=0, sdi is sampled on rising sclk edges and sdo changes on falling edges. With sample_fall=1, both edges are swapped.
- R3: Packet bit order as sampled: bit 0 is the direction (1 = read, 0 = write), bit 1 is command/data (0 = command, 1 = data), bit 2 is the half flag (1 = high, 0 = low), bits 3 to 7 are ignored, and bits 8 to 15 are the payload, MSB first.
- R4: Each completed write packet raises data_valid for one cycle, with data_byte set to the payload and data_dc set to the command/data flag. A command packet with the high flag stores the payload as the address high half. A command packet with the low flag raises addr_valid in the same cycle, with addr set to {stored high half, payload}.
- R5: If cs_n stays low after bit 15, the next sampling edge is bit 0 of a new packet.
- R6: A read with command/data = 0 raises rd_req for one cycle after the 8th sampling edge, with rd_mem=0 and addr holding the assembled address. rd_data must be valid from the cycle after rd_req. It is shifted out MSB first: one bit per output edge, starting at the output edge after sampling edge 8, so that each bit is stable at sampling edges 9 to 16.
- R7: A read with command/data = 1 inserts DUMMY_CLKS (default 16) dummy clocks after the control byte, with sdo_oe low. rd_req with rd_mem=1 is raised after sampling edge 8+DUMMY_CLKS, and the byte is then shifted out in the same way over the next 8 clocks.
- R8: sdo_oe is high only from the first output edge of read payload until the last sampling edge of that read. sdo is 0 whenever sdo_oe is low.
- R9: After a read completes, further clocks are ignored until cs_n rises: no strobes, and sdo_oe stays low.
- R10: The stored address high half survives a dropped packet and a select cycle, so a low-half packet sent afterwards completes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from host |
| sample_fall | input | 1 | 0: sample on rising sclk, 1: sample on falling sclk |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for sdo (low = high impedance) |
| data_valid | output | 1 | One-cycle pulse per completed write packet |
| data_byte | output | 8 | Payload of the last write packet |
| data_dc | output | 1 | Command/data flag of the last write packet |
| addr_valid | output | 1 | One-cycle pulse when a 16-bit address is complete |
| addr | output | 16 | Assembled command address |
| rd_req | output | 1 | One-cycle read request |
| rd_mem | output | 1 | Read request is a memory read |
| rd_data | input | 8 | Byte to return for the current read |

## Verification
If the bit counter or the captured control flags go wrong, the error shows at the ports within one packet. It appears as a missing or extra data_valid, a misrouted data_dc, or an address whose halves are swapped or stale. A fault in read framing shows on sdo at the very next sampling edge: a bit arrives a clock early or late, sdo_oe is high during dummy clocks, or the request fires at the wrong edge count. A state machine that fails to hold after a read gives itself away when a write packet sent in the same select cycle produces a strobe.

// File: rtl/spi16_pkg.sv
package spi16_pkg;

    // Bits sampled per packet section
    localparam int CTRL_BITS = 8;
    localparam int PAY_BITS  = 8;
    localparam int PKT_BITS  = CTRL_BITS + PAY_BITS;
    // Number of leading flag bits inside the control byte
    localparam int FLAG_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // select high
        ST_RX   = 2'd1,   // receiving a packet
        ST_RD   = 2'd2,   // read turnaround / return
        ST_HOLD = 2'd3    // read done, wait for select high
    } frm_state_e;

endpackage

// File: rtl/spi16_sync.sv
module spi16_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi16_edge.sv
module spi16_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sample_fall,
    output logic sample_p,
    output logic drive_p
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d   = sclk_s;
        rise     = sclk_s & ~prev_q;
        fall     = ~sclk_s & prev_q;
        sample_p = sample_fall ? fall : rise;
        drive_p  = sample_fall ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi16_txshift.sv
module spi16_txshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         clear,
    input  logic [W-1:0] din,
    output logic         sdo,
    output logic         oe
);
    logic [W-1:0] sr_d, sr_q;
    logic         oe_d, oe_q;

    always_comb begin
        sr_d = sr_q;
        oe_d = oe_q;
        if (clear) begin
            oe_d = 1'b0;
        end else if (load) begin
            sr_d = din;
            oe_d = 1'b1;
        end else if (shift) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            oe_q <= 1'b0;
        end else begin
            sr_q <= sr_d;
            oe_q <= oe_d;
        end
    end

    assign sdo = oe_q & sr_q[W-1];
    assign oe  = oe_q;

    AST_LOAD_NOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !clear); // R8
endmodule

// File: rtl/spi16_reg_slave.sv
module spi16_reg_slave
    import spi16_pkg::*;
#(
    parameter int DUMMY_CLKS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    input  logic        sample_fall,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        data_valid,
    output logic [7:0]  data_byte,
    output logic        data_dc,
    output logic        addr_valid,
    output logic [15:0] addr,
    output logic        rd_req,
    output logic        rd_mem,
    input  logic [7:0]  rd_data
);
    localparam int BYTE_W  = PAY_BITS;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int MAX_CNT = CTRL_BITS + DUMMY_CLKS + PAY_BITS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    localparam logic [CNT_W-1:0] CNT_FLAGS   = CNT_W'(FLAG_BITS);
    localparam logic [CNT_W-1:0] CNT_CTRL    = CNT_W'(CTRL_BITS);
    localparam logic [CNT_W-1:0] CNT_PKT     = CNT_W'(PKT_BITS);
    localparam logic [CNT_W-1:0] CNT_MEM_ST  = CNT_W'(CTRL_BITS + DUMMY_CLKS);
    localparam logic [CNT_W-1:0] CNT_REG_END = CNT_W'(CTRL_BITS + PAY_BITS);
    localparam logic [CNT_W-1:0] CNT_MEM_END = CNT_W'(MAX_CNT);

    typedef struct packed {
        frm_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sr;
        logic                f_rw;
        logic                f_dc;
        logic                f_hl;
        logic [BYTE_W-1:0]   addr_hi;
        logic [ADDR_W-1:0]   addr;
        logic                av;
        logic [BYTE_W-1:0]   dbyte;
        logic                ddc;
        logic                dv;
        logic                rdreq;
        logic                rdmem;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [2:0]        sync_out;
    logic              cs_s, sclk_s, sdi_s;
    logic              sample_p, drive_p;
    logic [CNT_W-1:0]  cnt_inc, start_idx;
    logic              tx_load, tx_shift, tx_clear;

    spi16_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, sdi}),
        .dout (sync_out)
    );
    assign {cs_s, sclk_s, sdi_s} = sync_out;

    spi16_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sample_fall(sample_fall),
        .sample_p   (sample_p),
        .drive_p    (drive_p)
    );

    always_comb begin
        frm_d       = frm_q;
        frm_d.dv    = 1'b0;
        frm_d.av    = 1'b0;
        frm_d.rdreq = 1'b0;
        cnt_inc     = frm_q.cnt + 1'b1;
        start_idx   = frm_q.rdmem ? CNT_MEM_ST : CNT_CTRL;

        if (cs_s) begin
            frm_d.st  = ST_IDLE;
            frm_d.cnt = '0;
        end else begin
            unique case (frm_q.st)
                ST_IDLE: begin
                    frm_d.st  = ST_RX;
                    frm_d.cnt = '0;
                end
                ST_RX: if (sample_p) begin
                    frm_d.sr  = {frm_q.sr[BYTE_W-2:0], sdi_s};
                    frm_d.cnt = cnt_inc;
                    if (cnt_inc == CNT_FLAGS) begin
                        frm_d.f_rw = frm_d.sr[2];
                        frm_d.f_dc = frm_d.sr[1];
                        frm_d.f_hl = frm_d.sr[0];
                    end
                    if (cnt_inc == CNT_CTRL && frm_q.f_rw) begin
                        frm_d.st    = ST_RD;
                        frm_d.rdmem = frm_q.f_dc;
                        frm_d.rdreq = ~frm_q.f_dc;
                    end else if (cnt_inc == CNT_PKT) begin
                        frm_d.cnt   = '0;
                        frm_d.dv    = 1'b1;
                        frm_d.dbyte = frm_d.sr;
                        frm_d.ddc   = frm_q.f_dc;
                        if (!frm_q.f_dc) begin
                            if (frm_q.f_hl) begin
                                frm_d.addr_hi = frm_d.sr;
                            end else begin
                                frm_d.addr = {frm_q.addr_hi, frm_d.sr};
                                frm_d.av   = 1'b1;
                            end
                        end
                    end
                end
                ST_RD: if (sample_p) begin
                    frm_d.cnt = cnt_inc;
                    if (frm_q.rdmem && cnt_inc == CNT_MEM_ST) frm_d.rdreq = 1'b1;
                    if (cnt_inc == (frm_q.rdmem ? CNT_MEM_END : CNT_REG_END))
                        frm_d.st = ST_HOLD;
                end
                default: ;
            endcase
        end

        tx_clear = (frm_d.st != ST_RD);
        tx_load  = drive_p && (frm_q.st == ST_RD) && (frm_q.cnt == start_idx) && !tx_clear;
        tx_shift = drive_p && (frm_q.st == ST_RD) && (frm_q.cnt > start_idx) && !tx_clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q    <= '0;
            frm_q.st <= ST_IDLE;
        end else begin
            frm_q    <= frm_d;
        end
    end

    spi16_txshift #(.W(BYTE_W)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tx_load),
        .shift(tx_shift),
        .clear(tx_clear),
        .din  (rd_data),
        .sdo  (sdo),
        .oe   (sdo_oe)
    );

    assign data_valid = frm_q.dv;
    assign data_byte  = frm_q.dbyte;
    assign data_dc    = frm_q.ddc;
    assign addr_valid = frm_q.av;
    assign addr       = frm_q.addr;
    assign rd_req     = frm_q.rdreq;
    assign rd_mem     = frm_q.rdmem;

    AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !data_valid && !addr_valid && !rd_req); // R1
    AST_ADDR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> data_valid && !data_dc); // R4
    AST_RDREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R6
    AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> frm_q.st == ST_RD); // R8
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.st == ST_HOLD) |=> !data_valid && !rd_req && !sdo_oe); // R9
    AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo); // R8
endmodule

// File: tb/spi16_reg_slave_tb_top.sv
module spi16_reg_slave_tb_top;
    localparam int H = 6;   // system clocks per sclk half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sample_fall = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        sdo, sdo_oe, data_valid, data_dc, addr_valid, rd_req, rd_mem;
    logic [7:0]  data_byte;
    logic [15:0] addr;

    int checks = 0;
    int errors = 0;
    int dv_cnt = 0, av_cnt = 0, rq_cnt = 0;
    logic [7:0]  last_byte = '0;
    logic        last_dc = 1'b0;
    logic [15:0] last_addr = '0, last_rq_addr = '0;
    logic        last_rq_mem = 1'b0;

    always #5 clk = ~clk;

    spi16_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sample_fall(sample_fall), .sdo(sdo), .sdo_oe(sdo_oe),
        .data_valid(data_valid), .data_byte(data_byte), .data_dc(data_dc),
        .addr_valid(addr_valid), .addr(addr), .rd_req(rd_req),
        .rd_mem(rd_mem), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid) begin dv_cnt++; last_byte = data_byte; last_dc = data_dc; end
            if (addr_valid) begin av_cnt++; last_addr = addr; end
            if (rd_req) begin rq_cnt++; last_rq_addr = addr; last_rq_mem = rd_mem; end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit: setup, sample edge, output edge; sdo/oe read just before sample edge
    task automatic xfer_bit(input logic b, output logic rx, output logic oe);
        sdi = b;
        wait_cyc(H);
        rx = sdo;
        oe = sdo_oe;
        sclk = ~sclk;
        wait_cyc(H);
        sclk = ~sclk;
    endtask

    task automatic select(input logic lvl);
        cs_n = lvl;
        wait_cyc(4);
    endtask

    task automatic set_mode(input logic m);
        sample_fall = m;
        sclk = m;
        wait_cyc(4);
    endtask

    task automatic send_write(input logic dc, input logic hl, input logic [7:0] pay);
        logic [15:0] bits;
        logic r, o;
        bits = {1'b0, dc, hl, 5'b00000, pay};
        for (int i = 15; i >= 0; i--) xfer_bit(bits[i], r, o);
    endtask

    // read: control byte, optional dummy clocks, 8 payload bits captured from sdo
    task automatic do_read(input logic mem, input logic [7:0] exp, input string tag);
        logic [7:0] ctrl, got;
        logic r, o, oe_bad_early, oe_bad_pay;
        int rq0;
        ctrl = {1'b1, mem, 1'b0, 5'b00000};
        oe_bad_early = 1'b0;
        oe_bad_pay = 1'b0;
        got = '0;
        rq0 = rq_cnt;
        rd_data = exp;
        select(1'b0);
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(ctrl[i], r, o);
            if (o) oe_bad_early = 1'b1;
        end
        if (mem) begin
            check({tag, " R7 no request during dummy"}, rq_cnt, rq0);
            for (int i = 0; i < 16; i++) begin
                xfer_bit(1'b0, r, o);
                if (o) oe_bad_early = 1'b1;
            end
        end
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b0, r, o);
            got[i] = r;
            if (!o) oe_bad_pay = 1'b1;
        end
        check({tag, " R8 oe low before payload"}, oe_bad_early, 1'b0);
        check({tag, " R8 oe high during payload"}, oe_bad_pay, 1'b0);
        check({tag, " R6 returned byte"}, got, exp);
        check({tag, " R6 one request"}, rq_cnt, rq0 + 1);
        check({tag, " R7 request kind"}, last_rq_mem, mem);
    endtask

    task automatic t_reset();
        check("R1 reset data_valid", data_valid, 0);
        check("R1 reset rd_req", rd_req, 0);
        check("R8 reset oe", sdo_oe, 0);
        check("R8 reset sdo", sdo, 0);
    endtask

    task automatic t_cs_high_ignored();
        logic r, o;
        int d0;
        d0 = dv_cnt;
        set_mode(1'b0);
        for (int i = 0; i < 32; i++) xfer_bit(i[0], r, o);
        check("R1 no strobe with cs high", dv_cnt, d0);
        check("R1 no request with cs high", rq_cnt, 0);
        check("R1 oe low with cs high", sdo_oe, 0);
    endtask

    task automatic t_addr_mode0();
        int a0, d0;
        a0 = av_cnt; d0 = dv_cnt;
        select(1'b0);
        send_write(1'b0, 1'b1, 8'hAB);
        check("R4 high half no addr strobe", av_cnt, a0);
        send_write(1'b0, 1'b0, 8'hCD);   // same select cycle
        select(1'b1);
        check("R5 two packets two strobes", dv_cnt, d0 + 2);
        check("R4 addr strobe count", av_cnt, a0 + 1);
        check("R3 R4 assembled addr", last_addr, 16'hABCD);
        check("R4 command flag", last_dc, 1'b0);
    endtask

    task automatic t_param();
        int a0;
        a0 = av_cnt;
        select(1'b0);
        send_write(1'b1, 1'b0, 8'hA5);
        select(1'b1);
        check("R4 param byte", last_byte, 8'hA5);
        check("R4 param flag", last_dc, 1'b1);
        check("R4 param no addr strobe", av_cnt, a0);
    endtask

    task automatic t_cs_fall_clock_high();
        sclk = 1'b1;               // mode 0 but clock high at select
        wait_cyc(4);
        select(1'b0);
        sclk = 1'b0;               // output edge, not a sample
        wait_cyc(H);
        send_write(1'b1, 1'b0, 8'h3C);
        select(1'b1);
        check("R1 start with clock high", last_byte, 8'h3C);
    endtask

    task automatic t_break();
        logic r, o;
        int d0;
        select(1'b0);
        send_write(1'b0, 1'b1, 8'h56);
        d0 = dv_cnt;
        for (int i = 0; i < 5; i++) xfer_bit(1'b1, r, o);
        select(1'b1);
        check("R1 broken packet dropped", dv_cnt, d0);
        select(1'b0);
        send_write(1'b0, 1'b0, 8'h78);
        select(1'b1);
        check("R10 high half kept over break", last_addr, 16'h5678);
    endtask

    task automatic t_mode1();
        set_mode(1'b1);
        select(1'b0);
        send_write(1'b0, 1'b1, 8'hBE);
        send_write(1'b0, 1'b0, 8'hEF);
        select(1'b1);
        check("R2 falling-edge sampling addr", last_addr, 16'hBEEF);
    endtask

    task automatic t_read_hold(input logic mem, input logic [7:0] v, input string tag);
        logic r, o;
        logic oe_seen;
        int d0;
        do_read(mem, v, tag);
        check({tag, " R6 request addr"}, last_rq_addr, last_addr);
        d0 = dv_cnt;
        oe_seen = 1'b0;
        send_write(1'b1, 1'b0, 8'hFF);   // after read, same select
        for (int i = 0; i < 4; i++) begin
            xfer_bit(1'b1, r, o);
            if (o) oe_seen = 1'b1;
        end
        check({tag, " R9 ignored after read"}, dv_cnt, d0);
        check({tag, " R9 oe low after read"}, oe_seen | sdo_oe, 1'b0);
        select(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_cs_high_ignored();
        t_addr_mode0();
        t_param();
        t_cs_fall_clock_high();
        t_break();
        t_read_hold(1'b0, 8'h96, "reg read m0");
        t_read_hold(1'b1, 8'hC3, "mem read m0");
        t_mode1();
        t_read_hold(1'b0, 8'h5A, "reg read m1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule